// File: doc/BRIEF.md
# EPROM Fast Programming Sequencer

This block burns a contiguous range of locations in a UV-erasable EPROM with bytes taken one at a time from a streaming source. It drives the memory's address lines and its eight data lines, including their direction, the combined chip-select/program strobe, the read strobe, an enable for the programming supply and a flag that puts the high voltage on the identification address line. All timing is counted in clock cycles. The program pulse width is derived from the clock frequency in MHz and the pulse length in microseconds.

A run begins with an identity check. The sequencer reads two code bytes with the high-voltage identification flag raised and compares them with the expected manufacturer and device values. If the identity matches, the sequencer takes one byte for each address and reads the current cell. It then applies a fixed-width program pulse and re-reads the cell, and repeats this until the cell holds the target byte or the pulse budget for that address is used up. Each finished address reports how many pulses it took. A running counter tracks how many addresses needed more than one pulse. The run ends with a one-cycle done strobe, a pass bit and, on failure, the offending address.

Top module: `eprom_prog_seq`

## Requirements
- R1: After `start`, the sequencer reads ID address 0 and then ID address 1, each for TDV_CYC cycles. During these reads `a9_hv` is 1, `rom_ce_n` and `rom_oe_n` are 0, and `rom_drive` and `vpp_en` are 0. The bytes read must be 0x8F and then 0x85. On a mismatch the run ends with `done`, `pass`=0 and `fail_addr` set to the ID address that mismatched (0 or 1). In that case no byte is taken and no pulse is issued.
- R2: Every program pulse holds `rom_ce_n` low for exactly PULSE_CYC = CLK_MHZ*PULSE_US cycles. During the pulse `vpp_en`=1, `rom_drive`=1 and `rom_dout` equals the target byte.
- R3: Before each pulse, `rom_addr` and `rom_dout` are held stable with `rom_drive`=1, `vpp_en`=1 and `rom_ce_n`=1 for SETUP_CYC cycles. `rom_ce_n` returns high when the pulse ends, so the strobe is never held low longer than one pulse.
- R4: After each pulse, `rom_drive` and `vpp_en` are released for at least one cycle before `rom_oe_n` falls. While `rom_oe_n` is 0, neither `rom_drive` nor `vpp_en` is ever 1. A verify read holds `rom_ce_n` and `rom_oe_n` low for TDV_CYC cycles and samples on the last of them.
- R5: Pulses are repeated until the verify read equals the target, up to MAX_PULSES (10) per address. When an address completes, `addr_done` is 1 for one cycle while `rom_addr` shows the address and `pulse_cnt` shows the number of pulses it took. An address that needs exactly 10 pulses still passes.
- R6: If the verify still mismatches after MAX_PULSES pulses, the run ends with `done`, `pass`=0 and `fail_addr` set to that address. No further bytes are taken.
- R7: A target byte of 0xFF is skipped. The location is not read and not pulsed, and it reports `pulse_cnt`=0.
- R8: If the pre-read cell has a 0 where the target has a 1, the run ends with `done`, `pass`=0 and `fail_addr` set to that address, and no pulse is issued.
- R9: If the pre-read cell already equals the target, the address completes with `pulse_cnt`=0 and no pulse.
- R10: `multi_cnt` is cleared at `start` and counts the completed addresses whose `pulse_cnt` is greater than 1.
- R11: Addresses are handled in ascending order from `first_addr` to `last_addr`, with one source byte taken per address (`src_ready` and `src_valid` both 1). After `last_addr` completes, `done` pulses for one cycle with `pass`=1.
- R12: In reset and while idle, `rom_ce_n`=1, `rom_oe_n`=1, `vpp_en`=0, `rom_drive`=0, `a9_hv`=0, `src_ready`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken while idle) |
| first_addr | input | ADDR_W | First location to program |
| last_addr | input | ADDR_W | Last location to program |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Sequencer takes the source byte this cycle |
| rom_addr | output | ADDR_W | Memory address lines |
| rom_dout | output | 8 | Byte driven onto the memory data lines |
| rom_drive | output | 1 | 1 = sequencer drives the data lines |
| rom_din | input | 8 | Byte read from the memory data lines |
| rom_ce_n | output | 1 | Chip select / program strobe, active low |
| rom_oe_n | output | 1 | Read strobe, active low |
| vpp_en | output | 1 | Programming supply enable |
| a9_hv | output | 1 | Apply high voltage to the identification address line |
| addr_done | output | 1 | One address finished |
| pulse_cnt | output | PC_W | Pulses used by the finished address |
| multi_cnt | output | CNT_W | Addresses that needed more than one pulse |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Result of the last run |
| fail_addr | output | ADDR_W | Failing address (or ID index) of the last run |

## Verification
The assertions assume that `first_addr` is not above `last_addr`. They also assume that `rom_din` reflects the addressed cell once `rom_ce_n` and `rom_oe_n` have both been low for TDV_CYC cycles, and that the source keeps `src_data` steady while `src_ready` is high. The bench models the memory so that data is returned only while both strobes are low. The model's cells only ever lose 1s, after a chosen number of complete pulses. The source byte advances only after the sequencer has taken it, and every run uses an ascending range. `start` is raised only while the block is idle.

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int ADDR_W     = 16,
  parameter int CLK_MHZ    = 250,
  parameter int PULSE_US   = 50,
  parameter int SETUP_CYC  = 4,
  parameter int TDV_CYC    = 4,
  parameter int MAX_PULSES = 10,
  parameter int CNT_W      = 16,
  parameter logic [7:0] ID_MFR = 8'h8F,
  parameter logic [7:0] ID_DEV = 8'h85,
  parameter int PC_W       = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              src_valid,
  input  logic [7:0]        src_data,
  output logic              src_ready,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [7:0]        rom_dout,
  output logic              rom_drive,
  input  logic [7:0]        rom_din,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              vpp_en,
  output logic              a9_hv,
  output logic              addr_done,
  output logic [PC_W-1:0]   pulse_cnt,
  output logic [CNT_W-1:0]  multi_cnt,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
  localparam int TOP_A     = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int TMR_TOP   = (TOP_A > TDV_CYC) ? TOP_A : TDV_CYC;
  localparam int TMR_W     = $clog2(TMR_TOP + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ID0, S_ID1, S_FETCH, S_READ,
    S_SETUP, S_PULSE, S_GAP, S_VERIFY, S_NEXT
  } st_t;

  st_t               st;
  logic [TMR_W-1:0]  tmr;
  logic [ADDR_W-1:0] addr, last_q, first_q;
  logic [7:0]        tgt;
  logic [PC_W-1:0]   pcnt;
  logic [CNT_W-1:0]  multi_q;
  logic              done_q, pass_q;
  logic [ADDR_W-1:0] fail_q;
  logic              tmr_end;

  assign tmr_end = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      addr    <= '0;
      last_q  <= '0;
      first_q <= '0;
      tgt     <= 8'hFF;
      pcnt    <= '0;
      multi_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!tmr_end) tmr <= tmr - 1'b1;
      case (st)
        S_IDLE:
          if (start) begin
            first_q <= first_addr;
            last_q  <= last_addr;
            addr    <= '0;
            multi_q <= '0;
            pass_q  <= 1'b0;
            fail_q  <= '0;
            tmr     <= TMR_W'(TDV_CYC - 1);
            st      <= S_ID0;
          end
        S_ID0:
          if (tmr_end) begin
            if (rom_din != ID_MFR) begin
              done_q <= 1'b1;
              fail_q <= addr;
              st     <= S_IDLE;
            end else begin
              addr <= ADDR_W'(1);
              tmr  <= TMR_W'(TDV_CYC - 1);
              st   <= S_ID1;
            end
          end
        S_ID1:
          if (tmr_end) begin
            if (rom_din != ID_DEV) begin
              done_q <= 1'b1;
              fail_q <= addr;
              st     <= S_IDLE;
            end else begin
              addr <= first_q;
              st   <= S_FETCH;
            end
          end
        S_FETCH:
          if (src_valid) begin
            tgt  <= src_data;
            pcnt <= '0;
            if (src_data == 8'hFF) st <= S_NEXT;
            else begin
              tmr <= TMR_W'(TDV_CYC - 1);
              st  <= S_READ;
            end
          end
        S_READ:
          if (tmr_end) begin
            if ((tgt & ~rom_din) != 8'h00) begin
              done_q <= 1'b1;
              fail_q <= addr;
              st     <= S_IDLE;
            end else if (rom_din == tgt) begin
              st <= S_NEXT;
            end else begin
              tmr <= TMR_W'(SETUP_CYC - 1);
              st  <= S_SETUP;
            end
          end
        S_SETUP:
          if (tmr_end) begin
            tmr <= TMR_W'(PULSE_CYC - 1);
            st  <= S_PULSE;
          end
        S_PULSE:
          if (tmr_end) begin
            pcnt <= pcnt + 1'b1;
            st   <= S_GAP;
          end
        S_GAP: begin
          tmr <= TMR_W'(TDV_CYC - 1);
          st  <= S_VERIFY;
        end
        S_VERIFY:
          if (tmr_end) begin
            if (rom_din == tgt) st <= S_NEXT;
            else if (pcnt == PC_W'(MAX_PULSES)) begin
              done_q <= 1'b1;
              fail_q <= addr;
              st     <= S_IDLE;
            end else begin
              tmr <= TMR_W'(SETUP_CYC - 1);
              st  <= S_SETUP;
            end
          end
        S_NEXT: begin
          if (pcnt > PC_W'(1)) multi_q <= multi_q + 1'b1;
          if (addr == last_q) begin
            done_q <= 1'b1;
            pass_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            addr <= addr + 1'b1;
            st   <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign src_ready = (st == S_FETCH);
  assign rom_addr  = addr;
  assign rom_dout  = tgt;
  assign rom_drive = (st == S_SETUP) || (st == S_PULSE);
  assign vpp_en    = rom_drive;
  assign a9_hv     = (st == S_ID0) || (st == S_ID1);
  assign rom_oe_n  = !((st == S_ID0) || (st == S_ID1) || (st == S_READ) || (st == S_VERIFY));
  assign rom_ce_n  = rom_oe_n && (st != S_PULSE);
  assign addr_done = (st == S_NEXT);
  assign pulse_cnt = pcnt;
  assign multi_cnt = multi_q;
  assign done      = done_q;
  assign pass      = pass_q;
  assign fail_addr = fail_q;

endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int ADDR_W     = 16,
  parameter int PULSE_CYC  = 12500,
  parameter int MAX_PULSES = 10,
  parameter int PC_W       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [7:0]        rom_dout,
  input logic              rom_drive,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              vpp_en,
  input logic              a9_hv,
  input logic              addr_done,
  input logic [PC_W-1:0]   pulse_cnt,
  input logic              done
);

  logic [31:0] wcnt;
  logic        in_pulse;

  assign in_pulse = !rom_ce_n && vpp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (in_pulse) wcnt <= wcnt + 1'b1;
    else wcnt <= '0;
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != 0 && !in_pulse) |-> (wcnt == PULSE_CYC));

  // R3
  no_dc_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= PULSE_CYC);

  // R3
  setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rom_ce_n) && vpp_en) |-> ($past(rom_drive) && $stable(rom_addr) && $stable(rom_dout)));

  // R4
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (!rom_drive && !vpp_en));

  // R4
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_oe_n) |-> !$past(rom_drive));

  // R1
  id_no_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a9_hv |-> (!vpp_en && !rom_drive && !rom_oe_n));

  // R5
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |-> (pulse_cnt <= PC_W'(MAX_PULSES)));

  // R11
  done_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .ADDR_W(ADDR_W),
  .PULSE_CYC(CLK_MHZ * PULSE_US),
  .MAX_PULSES(MAX_PULSES),
  .PC_W(PC_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .rom_addr(rom_addr),
  .rom_dout(rom_dout),
  .rom_drive(rom_drive),
  .rom_ce_n(rom_ce_n),
  .rom_oe_n(rom_oe_n),
  .vpp_en(vpp_en),
  .a9_hv(a9_hv),
  .addr_done(addr_done),
  .pulse_cnt(pulse_cnt),
  .done(done)
);

// File: tb/tb_eprom_prog_seq.sv
`timescale 1ns/1ps
module tb_eprom_prog_seq;
  localparam int AW    = 16;
  localparam int PW    = 4;
  localparam int P_CYC = 50;
  localparam int S_CYC = 2;
  localparam int T_CYC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic src_valid = 1'b1;
  logic [7:0] src_data;
  logic src_ready;
  logic [AW-1:0] rom_addr;
  logic [7:0] rom_dout, rom_din;
  logic rom_drive, rom_ce_n, rom_oe_n, vpp_en, a9_hv;
  logic addr_done;
  logic [PW-1:0] pulse_cnt;
  logic [15:0] multi_cnt;
  logic done, pass;
  logic [AW-1:0] fail_addr;

  always #2 clk = ~clk;

  eprom_prog_seq #(.ADDR_W(AW), .CLK_MHZ(1), .PULSE_US(50), .SETUP_CYC(S_CYC),
                   .TDV_CYC(T_CYC), .MAX_PULSES(10)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .last_addr(last_addr), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .rom_addr(rom_addr), .rom_dout(rom_dout),
    .rom_drive(rom_drive), .rom_din(rom_din), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .vpp_en(vpp_en), .a9_hv(a9_hv),
    .addr_done(addr_done), .pulse_cnt(pulse_cnt), .multi_cnt(multi_cnt),
    .done(done), .pass(pass), .fail_addr(fail_addr));

  logic [7:0] mem [0:255];
  int need [0:255];
  int mcnt [0:255];
  int rep  [0:255];
  logic [7:0] tgt [0:15];
  logic [7:0] id0 = 8'h8F, id1 = 8'h85;
  int sidx;

  assign src_data = tgt[sidx[3:0]];
  assign rom_din = (!rom_ce_n && !rom_oe_n) ?
                   (a9_hv ? (rom_addr[0] ? id1 : id0) : mem[rom_addr[7:0]]) : 8'hFF;

  int nchk = 0, nfail = 0;
  bit pend, prev_drive, done_seen, pass_seen;
  int lowc, setc, pulses, width_err, setup_err, cont_err, gap_err, order_err;
  int ndone, last_da, id_cyc, fail_seen, multi_seen;
  logic [7:0] pdata;
  int pa;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    pend = 0; prev_drive = 0; done_seen = 0; pass_seen = 0; sidx = 0;
    lowc = 0; setc = 0; pulses = 0; width_err = 0; setup_err = 0;
    cont_err = 0; gap_err = 0; order_err = 0; ndone = 0; last_da = 0;
    id_cyc = 0; fail_seen = -1; multi_seen = -1;
    for (int i = 0; i < 256; i++) rep[i] = -1;
  endtask

  task automatic tick();
    @(negedge clk);
    if (pend) begin sidx++; pend = 0; end
    if (src_ready && src_valid) pend = 1;
    if (!rom_ce_n && vpp_en) begin
      if (lowc == 0 && setc < S_CYC) setup_err++;
      lowc++; pdata = rom_dout; pa = int'(rom_addr[7:0]);
    end else if (lowc != 0) begin
      pulses++;
      if (lowc != P_CYC) width_err++;
      mcnt[pa]++;
      if (mcnt[pa] >= need[pa]) mem[pa] = mem[pa] & pdata;
      lowc = 0;
    end
    if (rom_drive && rom_ce_n && vpp_en) setc++;
    else if (rom_ce_n) setc = 0;
    if (!rom_oe_n && rom_drive) cont_err++;
    if (!rom_oe_n && prev_drive) gap_err++;
    prev_drive = rom_drive;
    if (addr_done) begin
      rep[rom_addr[7:0]] = int'(pulse_cnt);
      if (ndone > 0 && int'(rom_addr) != last_da + 1) order_err++;
      last_da = int'(rom_addr); ndone++;
    end
    if (a9_hv) id_cyc++;
    if (done) begin
      done_seen = 1; pass_seen = pass; fail_seen = int'(fail_addr);
      multi_seen = int'(multi_cnt);
    end
  endtask

  task automatic prep();
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; need[i] = 1; mcnt[i] = 0; end
    for (int i = 0; i < 16; i++) tgt[i] = 8'hFF;
    id0 = 8'h8F; id1 = 8'h85;
  endtask

  task automatic run(input int fa, input int la);
    int n;
    mon_clear();
    first_addr = AW'(fa); last_addr = AW'(la);
    start = 1'b1;
    tick();
    start = 1'b0;
    n = 0;
    while (!done_seen && n < 20000) begin tick(); n++; end
    repeat (3) tick();
    check("run completes (done strobe)", int'(done_seen), 1);
  endtask

  task automatic t_reset();
    check("R12 ce_n in reset", int'(rom_ce_n), 1);
    check("R12 oe_n in reset", int'(rom_oe_n), 1);
    check("R12 vpp/drive/a9/ready/done in reset",
          int'({vpp_en, rom_drive, a9_hv, src_ready, done}), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R12 idle strobes after reset", int'({rom_ce_n, rom_oe_n}), 3);
    check("R12 idle outputs after reset", int'({vpp_en, rom_drive, a9_hv, src_ready}), 0);
  endtask

  task automatic t_normal();
    prep();
    tgt[0] = 8'hFF; tgt[1] = 8'h00; tgt[2] = 8'h5A;
    tgt[3] = 8'h3C; tgt[4] = 8'hA5; tgt[5] = 8'h81;
    mem[8'h12] = 8'h5A;
    need[8'h13] = 3; need[8'h14] = 2;
    run(16'h10, 16'h15);
    check("R11 pass", int'(pass_seen), 1);
    check("R11 bytes taken", sidx, 6);
    check("R11 ascending order", order_err, 0);
    check("R11 addresses completed", ndone, 6);
    check("R1 id read cycles", id_cyc, 2 * T_CYC);
    check("R7 skip 0xFF pulse_cnt", rep[8'h10], 0);
    check("R9 equal cell pulse_cnt", rep[8'h12], 0);
    check("R5 one-pulse address", rep[8'h11], 1);
    check("R5 three-pulse address", rep[8'h13], 3);
    check("R5 two-pulse address", rep[8'h14], 2);
    check("R5 total pulses", pulses, 7);
    check("R5 programmed 0x13", int'(mem[8'h13]), 8'h3C);
    check("R5 programmed 0x14", int'(mem[8'h14]), 8'hA5);
    check("R10 multi_cnt", multi_seen, 2);
    check("R2 pulse width errors", width_err, 0);
    check("R3 setup errors", setup_err, 0);
    check("R4 contention", cont_err, 0);
    check("R4 turnaround gap", gap_err, 0);
  endtask

  task automatic t_cap();
    prep();
    tgt[0] = 8'h11; tgt[1] = 8'h22; tgt[2] = 8'h33;
    need[8'h21] = 11;
    run(16'h20, 16'h22);
    check("R6 pass low", int'(pass_seen), 0);
    check("R6 fail_addr", fail_seen, 16'h21);
    check("R6 pulses issued", pulses, 11);
    check("R6 no report for failed address", rep[8'h21], -1);
    check("R6 no further bytes", sidx, 2);
    check("R2 width errors in cap run", width_err, 0);
  endtask

  task automatic t_ten();
    prep();
    tgt[0] = 8'h00;
    need[8'h30] = 10;
    run(16'h30, 16'h30);
    check("R5 ten pulses pass", int'(pass_seen), 1);
    check("R5 ten pulses reported", rep[8'h30], 10);
    check("R10 multi_cnt cleared and counted", multi_seen, 1);
  endtask

  task automatic t_unprog();
    prep();
    tgt[0] = 8'hF3; tgt[1] = 8'h00;
    mem[8'h40] = 8'h0F;
    run(16'h40, 16'h41);
    check("R8 pass low", int'(pass_seen), 0);
    check("R8 fail_addr", fail_seen, 16'h40);
    check("R8 no pulse", pulses, 0);
    check("R8 cell untouched", int'(mem[8'h40]), 8'h0F);
  endtask

  task automatic t_id();
    prep();
    tgt[0] = 8'h00;
    id0 = 8'h8E;
    run(16'h50, 16'h50);
    check("R1 bad mfr pass low", int'(pass_seen), 0);
    check("R1 bad mfr fail_addr", fail_seen, 0);
    check("R1 bad mfr no bytes", sidx, 0);
    check("R1 bad mfr no pulse", pulses, 0);
    prep();
    tgt[0] = 8'h00;
    id1 = 8'h86;
    run(16'h50, 16'h50);
    check("R1 bad dev pass low", int'(pass_seen), 0);
    check("R1 bad dev fail_addr", fail_seen, 1);
    check("R1 bad dev no pulse", pulses, 0);
  endtask

  initial begin
    prep();
    mon_clear();
    repeat (3) @(negedge clk);
    t_reset();
    t_normal();
    t_unprog();
    t_cap();
    t_ten();
    t_id();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end
endmodule